// File: doc/BRIEF.md
# Configuration Request TLP Packetizer

This block sits between a configuration-access requester and the transmit side of a PCI Express root port. It takes one configuration read or write at a time, described by target bus, device/function, byte offset, access size and write data. It turns the request into a three-dword configuration request header plus one data dword. The packet leaves as 64-bit beats on a valid/ready stream, and each beat carries a lower dword, an upper dword and start/end-of-packet flags.

Before anything is sent, the request is screened. Accesses to the root port's own first base address register are refused. Accesses to a non-zero slot on the root bus are refused. Accesses to a downstream bus are refused while the link is down. Refused requests answer at once and produce no beats. A request that goes out waits for a separate completion block to report success or failure, together with the returned dword. The block then issues a response carrying status and the lane-extracted read data. It also keeps the root bus number, which it learns from successful writes to its own primary-bus register.

Top module: `cfg_tlp_packer`

## Requirements
- R1: Header dword 0 holds the format/type byte in bits 31:24 and a length of 1 in its low bits. The byte is 0x04 for a read and 0x44 for a write when the target bus equals the stored root bus. Otherwise it is 0x05 for a read and 0x45 for a write.
- R2: Header dword 1 holds {root bus, 8'h00} in bits 31:16, the tag in bits 15:8 and the byte enables in bits 3:0, with all other bits zero. The tag is 0x1D for a read and 0x10 for a write.
- R3: Header dword 2 holds the target bus in bits 31:24, the device/function in bits 23:16 and the byte offset with bits 1:0 forced to zero in bits 15:0.
- R4: The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. For 1 byte the byte enables are 4'b0001 shifted left by offset[1:0], and for 2 bytes they are 4'b0011 shifted left by offset[1:0], truncated to 4 bits. For 4 bytes they are 4'hF. Write data is masked to the access size and shifted left by 8*offset[1:0], truncated to 32 bits.
- R5: The first beat of every packet carries dword 0 low and dword 1 high, with start-of-packet set and end-of-packet clear.
- R6: A write whose offset[2:0] is zero takes three beats. The second beat carries dword 2 low and zero high, with no flags. The third beat carries the shifted data low and zero high, with end-of-packet set.
- R7: Every other request takes two beats. The second beat carries dword 2 low and the data high, with end-of-packet set; for a read the data is zero. After the end-of-packet beat is taken, no beat is offered until a new request is accepted.
- R8: An access to the root bus with device/function 0 and byte offset 0x10 sends no beats. One cycle after acceptance it answers with status 1 (bad register) and data 0xFFFFFFFF.
- R9: An access is refused with status 2 (no device) and data 0xFFFFFFFF, one cycle after acceptance and with no beats, in two cases. The first is an access to the root bus with device number (devfn[7:3]) non-zero. The second is an access to any other bus while link_up is low.
- R10: After reset the stored root bus is ROOT_INIT. A completed, successful write to the root bus with aligned offset 0x18 sets it to bits 7:0 of the shifted write data. Nothing else changes it.
- R11: req_ready is high only when no request is outstanding. It goes low from acceptance until the cycle in which the response is presented, and rsp_valid is a one-cycle pulse.
- R12: For a sent request, the response comes one cycle after cpl_valid. With cpl_ok low the status is 2 and the data 0xFFFFFFFF. With cpl_ok high the status is 0. The read data is then cpl_data[8*o+:8] for a byte or cpl_data[16*o[1]+:16] for a halfword, each zero-extended, or the full dword. Here o is offset[1:0]. A write returns 0.
- R13: While beat_valid is high and beat_ready is low, beat_valid and all beat fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (7:3) and function (2:0) |
| req_offset | input | OFS_W | Byte offset in configuration space |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Unshifted write data |
| link_up | input | 1 | Link trained and usable |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken |
| beat_lo | output | 32 | Lower dword of the beat |
| beat_hi | output | 32 | Upper dword of the beat |
| beat_sop | output | 1 | First beat of a packet |
| beat_eop | output | 1 | Last beat of a packet |
| cpl_valid | input | 1 | Completion outcome for the outstanding request |
| cpl_ok | input | 1 | Completion reported success |
| cpl_data | input | 32 | Returned dword |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 bad register, 2 no device |
| rsp_rdata | output | 32 | Extracted read data or all ones |
| root_bus | output | 8 | Stored root bus number |

## Verification
The bench builds the block with OFS_W = 6 and ROOT_INIT = 0. This shrinks configuration space to 64 byte offsets, so every offset is swept against every size code, both directions and both a root and a downstream target. That sweep naturally reaches the hidden register at 0x10, the primary-bus register at 0x18 and every byte-lane and quadword-alignment combination. Because root-bus writes in the sweep move the stored root bus, later type-0/type-1 selection and requester IDs are checked against a bench-side tracked copy. Directed cases add link-down refusal, non-zero slots, failed completions and stalled beats.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int DW_W    = 32;
  localparam int BE_W    = 4;

  localparam logic [7:0] FT_RD_LOCAL  = 8'h04;
  localparam logic [7:0] FT_RD_REMOTE = 8'h05;
  localparam logic [7:0] FT_WR_LOCAL  = 8'h44;
  localparam logic [7:0] FT_WR_REMOTE = 8'h45;
  localparam logic [7:0] TAG_RD       = 8'h1D;
  localparam logic [7:0] TAG_WR       = 8'h10;
  localparam logic [9:0] LEN_ONE_DW   = 10'd1;

  localparam int HIDDEN_BAR_OFS = 'h10;
  localparam int PRIBUS_OFS     = 'h18;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_BADREG = 2'd1,
    RSP_NODEV  = 2'd2
  } rsp_code_e;

  // byte enables from size code and byte lane
  function automatic logic [BE_W-1:0] calc_be(input logic [1:0] sz, input logic [1:0] lane);
    case (sz)
      2'd0:    return 4'b0001 << lane;
      2'd1:    return 4'b0011 << lane;
      default: return 4'hF;
    endcase
  endfunction

  // write data masked to size and moved to its byte lane
  function automatic logic [DW_W-1:0] lane_data(input logic [1:0] sz, input logic [1:0] lane,
                                                input logic [DW_W-1:0] d);
    case (sz)
      2'd0:    return {24'b0, d[7:0]}  << {lane, 3'b000};
      2'd1:    return {16'b0, d[15:0]} << {lane, 3'b000};
      default: return d;
    endcase
  endfunction

  // read data pulled down from its byte lane
  function automatic logic [DW_W-1:0] pick_read(input logic [1:0] sz, input logic [1:0] lane,
                                                input logic [DW_W-1:0] d);
    logic [DW_W-1:0] sh_b, sh_h;
    sh_b = d >> {lane, 3'b000};
    sh_h = d >> {lane[1], 4'b0000};
    case (sz)
      2'd0:    return {24'b0, sh_b[7:0]};
      2'd1:    return {16'b0, sh_h[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [7:0] fmt_type(input logic wr, input logic local_bus);
    if (wr) return local_bus ? FT_WR_LOCAL : FT_WR_REMOTE;
    else    return local_bus ? FT_RD_LOCAL : FT_RD_REMOTE;
  endfunction

endpackage

// File: rtl/cfg_req_filter.sv
module cfg_req_filter
  import cfg_tlp_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFS_W-1:0]   offset,
  input  logic [BUS_W-1:0]   root_bus,
  input  logic               link_up,
  output logic               hide_bar,
  output logic               no_dev
);

  logic is_root;
  logic [4:0] dev_num;

  assign is_root  = (bus == root_bus);
  assign dev_num  = devfn[7:3];
  assign hide_bar = is_root && (devfn == '0) && (offset == OFS_W'(HIDDEN_BAR_OFS));
  assign no_dev   = is_root ? (dev_num != 5'd0) : !link_up;

endmodule

// File: rtl/cfg_hdr_builder.sv
module cfg_hdr_builder
  import cfg_tlp_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic               write,
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFS_W-1:0]   offset,
  input  logic [1:0]         size,
  input  logic [DW_W-1:0]    wdata,
  input  logic [BUS_W-1:0]   root_bus,
  output logic [DW_W-1:0]    hdr0,
  output logic [DW_W-1:0]    hdr1,
  output logic [DW_W-1:0]    hdr2,
  output logic [DW_W-1:0]    payload,
  output logic               pad_beat
);

  logic [OFS_W-1:0] ofs_dw;
  logic [BE_W-1:0]  be;
  logic [7:0]       tag;

  assign ofs_dw   = {offset[OFS_W-1:2], 2'b00};
  assign be       = calc_be(size, offset[1:0]);
  assign tag      = write ? TAG_WR : TAG_RD;

  assign hdr0     = {fmt_type(write, bus == root_bus), 14'b0, LEN_ONE_DW};
  assign hdr1     = {root_bus, 8'h00, tag, 4'b0000, be};
  assign hdr2     = {bus, devfn, 16'(ofs_dw)};
  assign payload  = write ? lane_data(size, offset[1:0], wdata) : '0;
  assign pad_beat = write && (offset[2:0] == 3'b000);

endmodule

// File: rtl/cfg_root_tracker.sv
module cfg_root_tracker
  import cfg_tlp_pkg::*;
#(
  parameter int               OFS_W     = 12,
  parameter logic [BUS_W-1:0] ROOT_INIT = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_evt,
  input  logic               done_ok,
  input  logic               write,
  input  logic [BUS_W-1:0]   bus,
  input  logic [OFS_W-1:0]   offset,
  input  logic [DW_W-1:0]    lane_wdata,
  output logic [BUS_W-1:0]   root_bus
);

  logic snoop_evt;

  assign snoop_evt = done_evt && done_ok && write && (bus == root_bus) &&
                     ({offset[OFS_W-1:2], 2'b00} == OFS_W'(PRIBUS_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         root_bus <= ROOT_INIT;
    else if (snoop_evt) root_bus <= lane_wdata[BUS_W-1:0];
  end

  // R10
  root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(root_bus) |-> $past(snoop_evt));

endmodule

// File: rtl/cfg_tlp_packer.sv
module cfg_tlp_packer
  import cfg_tlp_pkg::*;
#(
  parameter int         OFS_W     = 12,
  parameter logic [7:0] ROOT_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [7:0]       req_bus,
  input  logic [7:0]       req_devfn,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic             link_up,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [31:0]      beat_lo,
  output logic [31:0]      beat_hi,
  output logic             beat_sop,
  output logic             beat_eop,
  input  logic             cpl_valid,
  input  logic             cpl_ok,
  input  logic [31:0]      cpl_data,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [31:0]      rsp_rdata,
  output logic [7:0]       root_bus
);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAD, S_LAST, S_WAIT} seq_e;
  seq_e st, st_nx;

  // captured request
  logic               c_wr;
  logic [BUS_W-1:0]   c_bus;
  logic [DEVFN_W-1:0] c_devfn;
  logic [OFS_W-1:0]   c_ofs;
  logic [1:0]         c_size;
  logic [DW_W-1:0]    c_wdata;

  // named events
  logic acc_evt, fwd, beat_hs, eop_hs, cpl_evt;
  logic f_hide, f_nodev;
  logic [DW_W-1:0] hdr0, hdr1, hdr2, payload;
  logic pad_beat;

  cfg_req_filter #(.OFS_W(OFS_W)) u_filter (
    .bus(req_bus), .devfn(req_devfn), .offset(req_offset),
    .root_bus(root_bus), .link_up(link_up),
    .hide_bar(f_hide), .no_dev(f_nodev)
  );

  cfg_hdr_builder #(.OFS_W(OFS_W)) u_hdr (
    .write(c_wr), .bus(c_bus), .devfn(c_devfn), .offset(c_ofs),
    .size(c_size), .wdata(c_wdata), .root_bus(root_bus),
    .hdr0(hdr0), .hdr1(hdr1), .hdr2(hdr2), .payload(payload), .pad_beat(pad_beat)
  );

  cfg_root_tracker #(.OFS_W(OFS_W), .ROOT_INIT(ROOT_INIT)) u_root (
    .clk(clk), .rst_n(rst_n), .done_evt(cpl_evt), .done_ok(cpl_ok),
    .write(c_wr), .bus(c_bus), .offset(c_ofs), .lane_wdata(payload),
    .root_bus(root_bus)
  );

  assign req_ready = (st == S_IDLE);
  assign acc_evt   = req_valid && req_ready;
  assign fwd       = !f_hide && !f_nodev;
  assign beat_hs   = beat_valid && beat_ready;
  assign eop_hs    = beat_hs && beat_eop;
  assign cpl_evt   = (st == S_WAIT) && cpl_valid;

  // beat contents per state
  always_comb begin
    beat_valid = 1'b0;
    beat_lo    = '0;
    beat_hi    = '0;
    beat_sop   = 1'b0;
    beat_eop   = 1'b0;
    case (st)
      S_HDR: begin
        beat_valid = 1'b1;
        beat_lo    = hdr0;
        beat_hi    = hdr1;
        beat_sop   = 1'b1;
      end
      S_PAD: begin
        beat_valid = 1'b1;
        beat_lo    = hdr2;
      end
      S_LAST: begin
        beat_valid = 1'b1;
        beat_eop   = 1'b1;
        beat_lo    = pad_beat ? payload : hdr2;
        beat_hi    = pad_beat ? '0 : payload;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (acc_evt && fwd) st_nx = S_HDR;
      S_HDR:  if (beat_hs) st_nx = pad_beat ? S_PAD : S_LAST;
      S_PAD:  if (beat_hs) st_nx = S_LAST;
      S_LAST: if (beat_hs) st_nx = S_WAIT;
      S_WAIT: if (cpl_valid) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      c_wr    <= 1'b0;
      c_bus   <= '0;
      c_devfn <= '0;
      c_ofs   <= '0;
      c_size  <= '0;
      c_wdata <= '0;
    end else begin
      st <= st_nx;
      if (acc_evt && fwd) begin
        c_wr    <= req_write;
        c_bus   <= req_bus;
        c_devfn <= req_devfn;
        c_ofs   <= req_offset;
        c_size  <= req_size;
        c_wdata <= req_wdata;
      end
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= RSP_OK;
      rsp_rdata  <= '0;
    end else if (acc_evt && !fwd) begin
      rsp_valid  <= 1'b1;
      rsp_status <= f_hide ? RSP_BADREG : RSP_NODEV;
      rsp_rdata  <= '1;
    end else if (cpl_evt) begin
      rsp_valid  <= 1'b1;
      rsp_status <= cpl_ok ? RSP_OK : RSP_NODEV;
      rsp_rdata  <= !cpl_ok ? '1 : (c_wr ? '0 : pick_read(c_size, c_ofs[1:0], cpl_data));
    end else begin
      rsp_valid  <= 1'b0;
    end
  end

  // R13
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_lo) && $stable(beat_hi)
                                  && $stable(beat_sop) && $stable(beat_eop));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R5
  sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_sop |-> !beat_eop);

  // R7
  eop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_hs |=> !beat_valid);

  // R8
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt && !fwd |=> !beat_valid && rsp_valid);

  // R9
  fail_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_status != RSP_OK) |-> rsp_rdata == 32'hFFFF_FFFF);

endmodule

// File: tb/test_cfg_tlp_packer.sv
`timescale 1ns/1ps
module test_cfg_tlp_packer;

  localparam int OFS_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [7:0] req_bus = '0, req_devfn = '0;
  logic [OFS_W-1:0] req_offset = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic link_up = 1'b1;
  logic beat_valid, beat_sop, beat_eop;
  logic beat_ready = 1'b0;
  logic [31:0] beat_lo, beat_hi;
  logic cpl_valid = 1'b0, cpl_ok = 1'b0;
  logic [31:0] cpl_data = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [31:0] rsp_rdata;
  logic [7:0] root_bus;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_root = 8'h00;

  always #2.5 clk = ~clk;

  cfg_tlp_packer #(.OFS_W(OFS_W), .ROOT_INIT(8'h00)) i_cfg_tlp_packer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .req_size(req_size), .req_wdata(req_wdata), .link_up(link_up),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_lo(beat_lo),
    .beat_hi(beat_hi), .beat_sop(beat_sop), .beat_eop(beat_eop),
    .cpl_valid(cpl_valid), .cpl_ok(cpl_ok), .cpl_data(cpl_data),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .root_bus(root_bus)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // access width in bytes from the size code
  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] m_be(input logic [1:0] sz, input int o);
    int w = nbytes(sz);
    if (w == 4) return 4'hF;
    return 4'((((1 << w) - 1) << o) & 15);
  endfunction

  function automatic logic [31:0] m_wd(input logic [1:0] sz, input int o, input logic [31:0] d);
    longint w = nbytes(sz);
    longint v;
    if (w == 4) return d;
    v = (longint'(d) & ((64'd1 << (8 * w)) - 1)) * (64'd1 << (8 * o));
    return 32'(v);
  endfunction

  function automatic logic [31:0] m_rd(input logic [1:0] sz, input int o, input logic [31:0] d);
    int w = nbytes(sz);
    if (w == 4) return d;
    if (w == 1) return (d / (32'd1 << (8 * o))) % 32'd256;
    return (d / (32'd1 << (8 * (o & 2)))) % 32'd65536;
  endfunction

  task automatic run(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                     input int off, input logic [1:0] sz, input logic [31:0] wd,
                     input bit cok, input logic [31:0] cd, input bit stall);
    bit to_root, bad, nodev, pad;
    int nb, o;
    logic [31:0] elo [3];
    logic [31:0] ehi [3];
    logic [1:0]  efl [3];
    string tlo [3];
    string thi [3];
    logic [31:0] pay, exp_rd;
    logic [7:0] ft;
    o       = off % 4;
    to_root = (bus == m_root);
    bad     = to_root && devfn == 8'h00 && off == 16;
    nodev   = to_root ? (devfn / 8 != 0) : !link_up;

    @(negedge clk);
    chk("R11 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_devfn = devfn;
    req_offset = OFS_W'(off); req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;

    if (bad || nodev) begin
      chk(bad ? "R8 reject rsp_valid" : "R9 reject rsp_valid", 32'(rsp_valid), 32'd1);
      chk(bad ? "R8 status" : "R9 status", 32'(rsp_status), bad ? 32'd1 : 32'd2);
      chk(bad ? "R8 data" : "R9 data", rsp_rdata, 32'hFFFF_FFFF);
      chk(bad ? "R8 no beat" : "R9 no beat", 32'(beat_valid), 32'd0);
      return;
    end

    ft  = (wr ? 8'h44 : 8'h04) + (to_root ? 8'h00 : 8'h01);
    pay = wr ? m_wd(sz, o, wd) : 32'h0;
    pad = wr && (off % 8 == 0);
    elo[0] = {ft, 24'h000001};
    ehi[0] = {m_root, 8'h00, wr ? 8'h10 : 8'h1D, 4'h0, m_be(sz, o)};
    efl[0] = 2'b10; tlo[0] = "R1 dword0"; thi[0] = "R2 dword1";
    if (pad) begin
      nb = 3;
      elo[1] = {bus, devfn, 16'(off - o)}; ehi[1] = 32'h0; efl[1] = 2'b00;
      tlo[1] = "R3 dword2 pad"; thi[1] = "R6 pad upper";
      elo[2] = pay; ehi[2] = 32'h0; efl[2] = 2'b01;
      tlo[2] = "R4 data aligned"; thi[2] = "R6 data upper";
    end else begin
      nb = 2;
      elo[1] = {bus, devfn, 16'(off - o)}; ehi[1] = pay; efl[1] = 2'b01;
      tlo[1] = "R3 dword2"; thi[1] = wr ? "R4 data" : "R7 read zero";
    end

    for (int i = 0; i < nb; i++) begin
      chk("R7 beat valid", 32'(beat_valid), 32'd1);
      chk("R11 busy not ready", 32'(req_ready), 32'd0);
      chk(tlo[i], beat_lo, elo[i]);
      chk(thi[i], beat_hi, ehi[i]);
      chk(i == 0 ? "R5 flags" : (pad ? "R6 flags" : "R7 flags"),
          32'({beat_sop, beat_eop}), 32'(efl[i]));
      if (stall && i == 0) begin
        @(negedge clk);
        chk("R13 hold valid", 32'(beat_valid), 32'd1);
        chk("R13 hold lo", beat_lo, elo[0]);
        chk("R13 hold hi", beat_hi, ehi[0]);
        chk("R13 hold flags", 32'({beat_sop, beat_eop}), 32'(efl[0]));
      end
      beat_ready = 1'b1;
      @(negedge clk);
      beat_ready = 1'b0;
    end

    chk("R7 no beat after eop", 32'(beat_valid), 32'd0);
    chk("R11 no early rsp", 32'(rsp_valid), 32'd0);
    cpl_valid = 1'b1; cpl_ok = cok; cpl_data = cd;
    @(negedge clk);
    cpl_valid = 1'b0;
    exp_rd = !cok ? 32'hFFFF_FFFF : (wr ? 32'h0 : m_rd(sz, o, cd));
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R12 status", 32'(rsp_status), cok ? 32'd0 : 32'd2);
    chk("R12 data", rsp_rdata, exp_rd);
    if (cok && wr && to_root && (off - o) == 24) m_root = pay[7:0];
    chk("R10 root bus", 32'(root_bus), 32'(m_root));
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset ready", 32'(req_ready), 32'd1);
    chk("R7 reset no beat", 32'(beat_valid), 32'd0);
    chk("R12 reset no rsp", 32'(rsp_valid), 32'd0);
    chk("R10 reset root", 32'(root_bus), 32'h00);
    rst_n = 1'b1;

    // sweep: every offset x size x direction x target
    for (int off = 0; off < 64; off++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int tg = 0; tg < 2; tg++) begin
            logic [7:0] bus, dfn;
            logic [31:0] wd, cd;
            bus = tg ? m_root + 8'd1 : m_root;
            dfn = tg ? 8'(off * 3 + sz) : 8'(off % 8);
            wd  = 32'hC3A5_9600 ^ (32'(off) * 32'h0101_0101) ^ 32'(sz * 7 + wr);
            cd  = 32'h8877_6655 ^ (32'(off) << 5) ^ 32'(sz);
            run(wr[0], bus, dfn, off, 2'(sz), wd, ((off + sz) % 7) != 3, cd, off[0]);
          end
        end
      end
    end

    // R9: downstream refused while link down
    link_up = 1'b0;
    run(1'b0, m_root + 8'd2, 8'h10, 4, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0);
    run(1'b1, m_root + 8'd2, 8'h00, 8, 2'd2, 32'h1234_5678, 1'b1, 32'h0, 1'b0);
    // root bus still reachable with link down
    run(1'b0, m_root, 8'h00, 0, 2'd2, 32'h0, 1'b1, 32'hDEAD_BEEF, 1'b0);
    link_up = 1'b1;
    // R9: non-zero slot on the root bus
    run(1'b0, m_root, 8'h08, 0, 2'd2, 32'h0, 1'b1, 32'h0, 1'b0);
    run(1'b1, m_root, 8'hF8, 4, 2'd0, 32'hAA, 1'b1, 32'h0, 1'b0);
    // R8 boundaries: function 1 and downstream bus reach offset 0x10
    run(1'b0, m_root, 8'h01, 16, 2'd2, 32'h0, 1'b1, 32'h0102_0304, 1'b0);
    run(1'b0, m_root + 8'd1, 8'h00, 16, 2'd2, 32'h0, 1'b1, 32'h0506_0708, 1'b1);
    run(1'b1, m_root, 8'h00, 16, 2'd2, 32'hFFFF_0000, 1'b1, 32'h0, 1'b0);
    // R10: root bus learned only on successful completion
    run(1'b1, m_root, 8'h00, 24, 2'd2, 32'h0000_0042, 1'b0, 32'h0, 1'b0);
    chk("R10 failed write keeps root", 32'(root_bus), 32'(m_root));
    run(1'b1, m_root, 8'h00, 24, 2'd2, 32'h0000_0042, 1'b1, 32'h0, 1'b0);
    chk("R10 root learned", 32'(root_bus), 32'h42);
    run(1'b0, 8'h42, 8'h00, 4, 2'd1, 32'h0, 1'b1, 32'hCAFE_F00D, 1'b1);
    run(1'b1, 8'h43, 8'h00, 24, 2'd2, 32'h0000_0077, 1'b1, 32'h0, 1'b0);
    chk("R10 downstream write ignored", 32'(root_bus), 32'h42);
    // R4: size code 3 behaves as 4 bytes
    run(1'b1, 8'h42, 8'h00, 36, 2'd3, 32'h89AB_CDEF, 1'b1, 32'h0, 1'b0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule